// File: doc/BRIEF.md
# Clock Calendar Core with Selectable Encoding

This block keeps wall-clock time and the calendar: seconds, minutes, hours, day of the week, day of the month, month, two-digit year and a century count. It advances by one second on each single-cycle pulse of `tick_i`, which is produced elsewhere from a one-hertz reference. Software loads any field through a simple write port: a field address, a data byte and a write strobe. While the set-mode input is high, no advance takes place, so a multi-byte load cannot be torn by a carry.

Two mode inputs decide how every field is presented and how written bytes are read: binary or packed BCD, and 24-hour or 12-hour hours with a PM flag. The time is held internally in binary 24-hour form, so either mode can be changed at any moment without corrupting the stored time. An optional daylight-saving rule moves the clock ahead one hour early on the first Sunday of April and back one hour, once, on the last Sunday of October. Each completed advance is signalled by a one-cycle pulse.

Top module: `rtc_calendar_core`

## Requirements
- R1: While `set_mode_i` is 1, a tick changes no field and raises no pulse; writes through the write port still take effect.
- R2: While `set_mode_i` is 0, each `tick_i` pulse advances the time by one second, with carries from seconds to minutes, hours, date, month, year and century.
- R3: With `bin_mode_i` = 1 every field is shown and written in plain binary; with 0 every field is packed BCD (tens in bits 7:4, units in bits 3:0).
- R4: With `hr24_i` = 1 the hour runs 0 to 23; with 0 bit 7 of the hour byte is 1 for PM and bits 6:0 hold 12, 1, ..., 11, the PM flag changing when 11 rolls to 12.
- R5: Day of week runs 1 to 7 (1 is Sunday) and steps from 7 back to 1 at midnight.
- R6: Months 4, 6, 9 and 11 have 30 days, February has 29 days when the year is a multiple of 4 and 28 otherwise, every other month has 31.
- R7: When the year rolls from 99 to 0 the century field increments (99 wraps to 0).
- R8: With `dst_en_i` = 1, a tick at 01:59:59 on a Sunday in April with date 1 to 7 gives 03:00:00.
- R9: With `dst_en_i` = 1, a tick at 01:59:59 on a Sunday in October with date 25 or later gives 01:00:00, at most once per day; the once-only mark is cleared at midnight or by a write to the date field.
- R10: With `dst_en_i` = 0 at 01:59:59 on either rule day, the tick gives the ordinary 02:00:00.
- R11: `upd_done_o` is 1 for exactly the clock after each advancing tick and 0 otherwise, in particular never for a tick in set mode.
- R12: Field addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 century; when a write coincides with an advancing tick, the advance is applied first and the written field then takes the written value.
- R13: Reset gives 00:00:00, day of week 1, date 1, month 1, year 0, century 20, and `upd_done_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| set_mode_i | input | 1 | 1 freezes time advance |
| bin_mode_i | input | 1 | 1 binary fields, 0 packed BCD |
| hr24_i | input | 1 | 1 for 24-hour, 0 for 12-hour with PM flag |
| dst_en_i | input | 1 | Enables the daylight-saving rule |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Field address |
| wr_data_i | input | 8 | Field value in the selected encoding |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| century_o | output | 8 | Century |
| upd_done_o | output | 1 | Pulse after each advance |

## Verification
A field write and an advancing tick can land in the same clock, and a daylight-saving jump can coincide with a 12-hour or BCD presentation change. The collision is provoked by a directed case that writes minutes on the tick that carries out of seconds, and by random stimulus that strobes writes, ticks and mode flips independently. The bench model advances its own time first and then overrides the written field, and it clears its own once-per-day mark on a date write, so a wrong merge order or a stale mark shows up as a field mismatch.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned NUM_FIELDS = 8;
  localparam int unsigned FIELD_W    = 7;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_W     = $clog2(NUM_FIELDS);

  typedef logic [FIELD_W-1:0] fld_t;
  typedef logic [ADDR_W-1:0]  fidx_t;
  typedef logic [BYTE_W-1:0]  byte_t;

  localparam fidx_t F_SEC  = 3'd0;
  localparam fidx_t F_MIN  = 3'd1;
  localparam fidx_t F_HOUR = 3'd2;
  localparam fidx_t F_DOW  = 3'd3;
  localparam fidx_t F_DATE = 3'd4;
  localparam fidx_t F_MON  = 3'd5;
  localparam fidx_t F_YEAR = 3'd6;
  localparam fidx_t F_CENT = 3'd7;

  typedef struct packed {
    fld_t cent;
    fld_t year;
    fld_t month;
    fld_t date;
    fld_t dow;
    fld_t hour;
    fld_t min;
    fld_t sec;
  } rtc_time_t;

  function automatic byte_t to_bcd(fld_t v);
    fld_t tens;
    fld_t ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic fld_t from_bcd(byte_t b);
    return {3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]};
  endfunction

  function automatic byte_t enc_field(fld_t v, logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic fld_t dec_field(byte_t b, logic bin);
    return bin ? b[6:0] : from_bcd(b);
  endfunction

  function automatic byte_t enc_hour(fld_t h, logic bin, logic h24);
    fld_t  h12;
    byte_t e;
    if (h24) return enc_field(h, bin);
    if (h == 7'd0)       h12 = 7'd12;
    else if (h > 7'd12)  h12 = h - 7'd12;
    else                 h12 = h;
    e = enc_field(h12, bin);
    return {(h >= 7'd12), e[6:0]};
  endfunction

  function automatic fld_t dec_hour(byte_t b, logic bin, logic h24);
    fld_t h12;
    fld_t base;
    if (h24) return dec_field(b, bin);
    h12  = dec_field({1'b0, b[6:0]}, bin);
    base = (h12 == 7'd12) ? 7'd0 : h12;
    return b[7] ? base + 7'd12 : base;
  endfunction

  function automatic fld_t month_days(fld_t m, fld_t y);
    case (m)
      7'd2:                     return (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction

  function automatic fld_t get_field(rtc_time_t t, fidx_t idx);
    case (idx)
      F_SEC:   return t.sec;
      F_MIN:   return t.min;
      F_HOUR:  return t.hour;
      F_DOW:   return t.dow;
      F_DATE:  return t.date;
      F_MON:   return t.month;
      F_YEAR:  return t.year;
      default: return t.cent;
    endcase
  endfunction

  function automatic rtc_time_t set_field(rtc_time_t t, fidx_t idx, fld_t v);
    rtc_time_t r;
    r = t;
    case (idx)
      F_SEC:   r.sec   = v;
      F_MIN:   r.min   = v;
      F_HOUR:  r.hour  = v;
      F_DOW:   r.dow   = v;
      F_DATE:  r.date  = v;
      F_MON:   r.month = v;
      F_YEAR:  r.year  = v;
      default: r.cent  = v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
#(
  parameter int unsigned SUNDAY_CODE     = 1,
  parameter int unsigned RULE_HOUR       = 1,
  parameter int unsigned FWD_TO_HOUR     = 3,
  parameter int unsigned FWD_MONTH       = 4,
  parameter int unsigned BACK_MONTH      = 10,
  parameter int unsigned FIRST_WEEK_LAST = 7,
  parameter int unsigned LAST_WEEK_FIRST = 25
) (
  input  rtc_time_t cur_i,
  input  logic      dst_en_i,
  input  logic      fb_done_i,
  output rtc_time_t nxt_o,
  output logic      fb_done_o,
  output logic      sec_wrap_o,
  output logic      dst_fwd_o,
  output logic      dst_back_o
);

  localparam fld_t LAST_SEC  = 7'd59;
  localparam fld_t LAST_MIN  = 7'd59;
  localparam fld_t LAST_HOUR = 7'd23;
  localparam fld_t LAST_DOW  = 7'd7;
  localparam fld_t LAST_MON  = 7'd12;
  localparam fld_t LAST_YEAR = 7'd99;

  logic at_rule_time;
  fld_t dim;

  always_comb begin
    nxt_o     = cur_i;
    fb_done_o = fb_done_i;
    dim       = month_days(cur_i.month, cur_i.year);

    at_rule_time = dst_en_i
                && cur_i.hour == fld_t'(RULE_HOUR)
                && cur_i.min  == LAST_MIN
                && cur_i.sec  == LAST_SEC
                && cur_i.dow  == fld_t'(SUNDAY_CODE);
    dst_fwd_o  = at_rule_time && cur_i.month == fld_t'(FWD_MONTH)
              && cur_i.date <= fld_t'(FIRST_WEEK_LAST);
    dst_back_o = at_rule_time && cur_i.month == fld_t'(BACK_MONTH)
              && cur_i.date >= fld_t'(LAST_WEEK_FIRST) && !fb_done_i;
    sec_wrap_o = cur_i.sec == LAST_SEC;

    if (dst_fwd_o) begin
      nxt_o.hour = fld_t'(FWD_TO_HOUR);
      nxt_o.min  = '0;
      nxt_o.sec  = '0;
    end else if (dst_back_o) begin
      nxt_o.hour = fld_t'(RULE_HOUR);
      nxt_o.min  = '0;
      nxt_o.sec  = '0;
      fb_done_o  = 1'b1;
    end else begin
      nxt_o.sec = sec_wrap_o ? 7'd0 : cur_i.sec + 7'd1;
      if (sec_wrap_o) begin
        nxt_o.min = (cur_i.min == LAST_MIN) ? 7'd0 : cur_i.min + 7'd1;
        if (cur_i.min == LAST_MIN) begin
          nxt_o.hour = (cur_i.hour == LAST_HOUR) ? 7'd0 : cur_i.hour + 7'd1;
          if (cur_i.hour == LAST_HOUR) begin
            fb_done_o  = 1'b0;
            nxt_o.dow  = (cur_i.dow >= LAST_DOW) ? 7'd1 : cur_i.dow + 7'd1;
            nxt_o.date = (cur_i.date >= dim) ? 7'd1 : cur_i.date + 7'd1;
            if (cur_i.date >= dim) begin
              nxt_o.month = (cur_i.month >= LAST_MON) ? 7'd1 : cur_i.month + 7'd1;
              if (cur_i.month >= LAST_MON) begin
                nxt_o.year = (cur_i.year >= LAST_YEAR) ? 7'd0 : cur_i.year + 7'd1;
                if (cur_i.year >= LAST_YEAR)
                  nxt_o.cent = (cur_i.cent >= LAST_YEAR) ? 7'd0 : cur_i.cent + 7'd1;
              end
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/rtc_write_merge.sv
module rtc_write_merge
  import rtc_pkg::*;
(
  input  rtc_time_t   base_i,
  input  logic        wr_en_i,
  input  fidx_t       wr_addr_i,
  input  byte_t       wr_data_i,
  input  logic        bin_i,
  input  logic        h24_i,
  output rtc_time_t   merged_o,
  output logic        date_wr_o
);

  fld_t wr_val;

  always_comb begin
    if (wr_addr_i == F_HOUR) wr_val = dec_hour(wr_data_i, bin_i, h24_i);
    else                     wr_val = dec_field(wr_data_i, bin_i);
    merged_o  = wr_en_i ? set_field(base_i, wr_addr_i, wr_val) : base_i;
    date_wr_o = wr_en_i && (wr_addr_i == F_DATE);
  end

endmodule

// File: rtl/rtc_out_codec.sv
module rtc_out_codec
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      bin_i,
  input  logic      h24_i,
  output byte_t     bytes_o [NUM_FIELDS]
);

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    if (fidx_t'(gi) == F_HOUR) begin : g_hour
      assign bytes_o[gi] = enc_hour(cur_i.hour, bin_i, h24_i);
    end else begin : g_plain
      assign bytes_o[gi] = enc_field(get_field(cur_i, fidx_t'(gi)), bin_i);
    end
  end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int unsigned RESET_CENTURY = 20,
  parameter int unsigned RESET_YEAR    = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       set_mode_i,
  input  logic       bin_mode_i,
  input  logic       hr24_i,
  input  logic       dst_en_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] century_o,
  output logic       upd_done_o
);

  localparam rtc_time_t RESET_TIME = '{
    cent:  fld_t'(RESET_CENTURY),
    year:  fld_t'(RESET_YEAR),
    month: 7'd1,
    date:  7'd1,
    dow:   7'd1,
    hour:  7'd0,
    min:   7'd0,
    sec:   7'd0
  };

  rtc_time_t cur_q;
  rtc_time_t adv_time;
  rtc_time_t base_time;
  rtc_time_t next_time;
  logic      fb_q;
  logic      fb_adv;
  logic      fb_next;
  logic      upd_q;
  logic      adv_en;
  logic      date_wr;
  byte_t     out_bytes [NUM_FIELDS];

  // named events for the bound checker
  logic ev_sec_wrap;
  logic ev_dst_fwd;
  logic ev_dst_back;

  assign adv_en = tick_i && !set_mode_i;

  rtc_advance u_adv (
    .cur_i      (cur_q),
    .dst_en_i   (dst_en_i),
    .fb_done_i  (fb_q),
    .nxt_o      (adv_time),
    .fb_done_o  (fb_adv),
    .sec_wrap_o (ev_sec_wrap),
    .dst_fwd_o  (ev_dst_fwd),
    .dst_back_o (ev_dst_back)
  );

  assign base_time = adv_en ? adv_time : cur_q;

  rtc_write_merge u_wr (
    .base_i    (base_time),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .bin_i     (bin_mode_i),
    .h24_i     (hr24_i),
    .merged_o  (next_time),
    .date_wr_o (date_wr)
  );

  // R9: date write restarts the once-per-day fall-back mark
  assign fb_next = date_wr ? 1'b0 : (adv_en ? fb_adv : fb_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= RESET_TIME;
      fb_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      cur_q <= next_time;
      fb_q  <= fb_next;
      upd_q <= adv_en;
    end
  end

  rtc_out_codec u_out (
    .cur_i   (cur_q),
    .bin_i   (bin_mode_i),
    .h24_i   (hr24_i),
    .bytes_o (out_bytes)
  );

  assign sec_o      = out_bytes[F_SEC];
  assign min_o      = out_bytes[F_MIN];
  assign hour_o     = out_bytes[F_HOUR];
  assign dow_o      = out_bytes[F_DOW];
  assign date_o     = out_bytes[F_DATE];
  assign month_o    = out_bytes[F_MON];
  assign year_o     = out_bytes[F_YEAR];
  assign century_o  = out_bytes[F_CENT];
  assign upd_done_o = upd_q;

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tick_i,
  input logic      set_mode_i,
  input logic      wr_en_i,
  input logic      upd_done_o,
  input rtc_time_t cur_q,
  input logic      sec_wrap,
  input logic      dst_fwd,
  input logic      dst_back
);

  assert_hold_in_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && set_mode_i && !wr_en_i) |=> $stable(cur_q));

  assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !set_mode_i && !wr_en_i && !sec_wrap) |=> (cur_q.sec == $past(cur_q.sec) + 7'd1));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !set_mode_i && !wr_en_i && sec_wrap) |=> (cur_q.sec == 7'd0));

  assert_dst_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !set_mode_i && !wr_en_i && dst_fwd)
      |=> (cur_q.hour == 7'd3 && cur_q.min == 7'd0 && cur_q.sec == 7'd0));

  assert_dst_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !set_mode_i && !wr_en_i && dst_back)
      |=> (cur_q.hour == 7'd1 && cur_q.min == 7'd0 && cur_q.sec == 7'd0));

  assert_no_pulse_in_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode_i && $past(set_mode_i)) |-> !upd_done_o);

  assert_pulse_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done_o |-> $past(tick_i));

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .set_mode_i (set_mode_i),
  .wr_en_i    (wr_en_i),
  .upd_done_o (upd_done_o),
  .cur_q      (cur_q),
  .sec_wrap   (ev_sec_wrap),
  .dst_fwd    (ev_dst_fwd),
  .dst_back   (ev_dst_back)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_ITERS = 3000;

  logic       clk;
  logic       rst_n;
  logic       tick, setm, binm, h24, dst, wr;
  logic [2:0] addr;
  logic [7:0] wdat;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, century_o;
  logic       upd_done_o;

  int total = 0;
  int bad   = 0;

  // bench model, binary 24-hour
  int ms, mmin, mh, mdw, md, mmo, my, mc;
  int mfb;
  int exp_upd;

  rtc_calendar_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .set_mode_i(setm),
    .bin_mode_i(binm), .hr24_i(h24), .dst_en_i(dst), .wr_en_i(wr),
    .wr_addr_i(addr), .wr_data_i(wdat),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .century_o(century_o), .upd_done_o(upd_done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int enc_b(int v);
    if (binm) return v;
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int enc_h(int h);
    int hh;
    if (h24) return enc_b(h);
    hh = h % 12;
    if (hh == 0) hh = 12;
    return ((h >= 12) ? 128 : 0) + enc_b(hh);
  endfunction

  function automatic int days_of(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_adv();
    bit rule;
    rule = dst && mh == 1 && mmin == 59 && ms == 59 && mdw == 1;
    if (rule && mmo == 4 && md <= 7) begin
      mh = 3; mmin = 0; ms = 0;
    end else if (rule && mmo == 10 && md >= 25 && mfb == 0) begin
      mh = 1; mmin = 0; ms = 0; mfb = 1;
    end else begin
      ms++;
      if (ms == 60) begin
        ms = 0; mmin++;
        if (mmin == 60) begin
          mmin = 0; mh++;
          if (mh == 24) begin
            mh = 0; mfb = 0;
            mdw = (mdw % 7) + 1;
            md++;
            if (md > days_of(mmo, my)) begin
              md = 1; mmo++;
              if (mmo == 13) begin
                mmo = 1; my++;
                if (my == 100) begin
                  my = 0; mc = (mc + 1) % 100;
                end
              end
            end
          end
        end
      end
    end
  endtask

  task automatic model_set(int a, int v);
    case (a)
      0: ms = v;
      1: mmin = v;
      2: mh = v;
      3: mdw = v;
      4: begin md = v; mfb = 0; end
      5: mmo = v;
      6: my = v;
      default: mc = v;
    endcase
  endtask

  task automatic chk(int act, int exp, string tag, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(int'(sec_o),     enc_b(ms),   tag, "seconds");
    chk(int'(min_o),     enc_b(mmin), tag, "minutes");
    chk(int'(hour_o),    enc_h(mh),   tag, "hours");
    chk(int'(dow_o),     enc_b(mdw),  tag, "dow");
    chk(int'(date_o),    enc_b(md),   tag, "date");
    chk(int'(month_o),   enc_b(mmo),  tag, "month");
    chk(int'(year_o),    enc_b(my),   tag, "year");
    chk(int'(century_o), enc_b(mc),   tag, "century");
    chk(int'(upd_done_o), exp_upd,    tag, "upd_done");
  endtask

  // one clock: drive after a falling edge, compare at the next falling edge
  task automatic cyc(bit t, bit w, int a, int v, string tag);
    tick = t;
    wr   = w;
    addr = a[2:0];
    wdat = w ? ((a == 2) ? enc_h(v) : enc_b(v)) : 8'h00;
    wdat = wdat[7:0];
    exp_upd = (t && !setm) ? 1 : 0;
    if (exp_upd == 1) model_adv();
    if (w) model_set(a, v);
    @(negedge clk);
    compare_all(tag);
    tick = 1'b0;
    wr   = 1'b0;
  endtask

  task automatic load(int c, int y, int mo, int d, int dw, int h, int mi, int s);
    bit keep;
    keep = setm;
    setm = 1'b1;
    cyc(0, 1, 7, c,  "R12");
    cyc(0, 1, 6, y,  "R12");
    cyc(0, 1, 5, mo, "R12");
    cyc(0, 1, 4, d,  "R12");
    cyc(0, 1, 3, dw, "R12");
    cyc(0, 1, 2, h,  "R12");
    cyc(0, 1, 1, mi, "R12");
    cyc(0, 1, 0, s,  "R1");
    setm = keep;
  endtask

  function automatic int rand_val(int a);
    case (a)
      0, 1:    return int'($urandom % 60);
      2:       return int'($urandom % 24);
      3:       return 1 + int'($urandom % 7);
      4:       return 1 + int'($urandom % 28);
      5:       return 1 + int'($urandom % 12);
      default: return int'($urandom % 100);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 0; setm = 0; binm = 0; h24 = 1; dst = 0; wr = 0;
    addr = '0; wdat = '0;
    ms = 0; mmin = 0; mh = 0; mdw = 1; md = 1; mmo = 1; my = 0; mc = 20;
    mfb = 0; exp_upd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R13");

    // R2 plain advance and R11 pulse then idle
    load(20, 24, 3, 14, 5, 10, 20, 30);
    cyc(1, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R11");
    binm = 1;
    cyc(1, 0, 0, 0, "R3");

    // R1 set mode freezes, writes still land
    setm = 1;
    cyc(1, 0, 0, 0, "R1");
    cyc(1, 1, 0, 45, "R1");
    setm = 0;
    binm = 0;

    // R4 12-hour presentation
    h24 = 0;
    load(20, 24, 6, 10, 2, 11, 59, 59);
    cyc(1, 0, 0, 0, "R4");
    load(20, 24, 6, 10, 2, 23, 59, 59);
    cyc(1, 0, 0, 0, "R4");
    cyc(0, 1, 2, 17, "R4");
    h24 = 1;
    cyc(0, 0, 0, 0, "R4");

    // R5 day-of-week wrap
    load(20, 24, 6, 15, 7, 23, 59, 59);
    cyc(1, 0, 0, 0, "R5");

    // R6 month lengths and leap years
    load(20, 24, 2, 28, 3, 23, 59, 59);
    cyc(1, 0, 0, 0, "R6");
    load(20, 24, 2, 29, 4, 23, 59, 59);
    cyc(1, 0, 0, 0, "R6");
    load(20, 23, 2, 28, 3, 23, 59, 59);
    cyc(1, 0, 0, 0, "R6");
    load(20, 23, 4, 30, 3, 23, 59, 59);
    cyc(1, 0, 0, 0, "R6");

    // R7 century carry
    load(20, 99, 12, 31, 6, 23, 59, 59);
    cyc(1, 0, 0, 0, "R7");

    // R8 spring forward
    dst = 1;
    load(20, 24, 4, 7, 1, 1, 59, 59);
    cyc(1, 0, 0, 0, "R8");

    // R9 fall back once per day, date write re-arms
    load(20, 24, 10, 27, 1, 1, 59, 59);
    cyc(1, 0, 0, 0, "R9");
    setm = 1;
    cyc(0, 1, 1, 59, "R9");
    cyc(0, 1, 0, 59, "R9");
    setm = 0;
    cyc(1, 0, 0, 0, "R9");
    load(20, 24, 10, 27, 1, 1, 59, 59);
    cyc(1, 0, 0, 0, "R9");

    // R10 rule disabled
    dst = 0;
    load(20, 24, 4, 3, 1, 1, 59, 59);
    cyc(1, 0, 0, 0, "R10");
    load(20, 24, 10, 30, 1, 1, 59, 59);
    cyc(1, 0, 0, 0, "R10");

    // R12 write coinciding with an advancing tick
    load(20, 24, 5, 12, 3, 10, 20, 59);
    cyc(1, 1, 1, 45, "R12");

    // random mix
    load(20, 24, 1, 1, 1, 23, 59, 40);
    for (int i = 0; i < RAND_ITERS; i++) begin
      int r, a, v;
      bit t, w;
      r = int'($urandom % 16);
      if (r == 0) binm = ~binm;
      if (r == 1) h24  = ~h24;
      if (r == 2) dst  = ~dst;
      setm = ($urandom % 8) == 0;
      t = ($urandom % 2) == 0;
      w = ($urandom % 4) == 0;
      a = int'($urandom % 8);
      v = rand_val(a);
      cyc(t, w, a, v, "R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule